// File: doc/BRIEF.md
# Halve-and-Double Sequential Multiplier

This block multiplies two unsigned operands over several clock cycles, using only a shifter and an adder. One operand must fit in the lower half of its width; the block finds which one does and uses it as the factor. In each cycle the factor is halved by a right shift. When the bit shifted out is 1, the current multiplier value is added into an accumulator. The multiplier is then doubled. The operation stops as soon as the remaining factor is zero, so small factors finish in fewer cycles.

A request is made by pulsing `start_i` with both operands. The block raises `busy_o`, spends one cycle picking the factor, and then runs at most one halve/add/double step per cycle. It ends with a single-cycle `done_o`. The product and the error flag stay on the outputs until the next accepted request. The error flag is set when neither operand fits in the lower half of its width, or when the result would not fit in the product width. On error the product reads as zero.

Top module: `hdm_mul_top`

## Requirements
- R1: If the upper half of `op_b_i` is zero, the lower half of `op_b_i` is the factor and `op_a_i` is the multiplier. Otherwise, if the upper half of `op_a_i` is zero, the roles are swapped. Either way the product equals `op_a_i * op_b_i`.
- R2: If both operands have a nonzero upper half, the block sets `error_o` to 1 and `product_o` to 0, and no iteration runs.
- R3: When the true product fits in the product width, `product_o` equals it and `error_o` is 0. This includes a zero factor and the largest product that fits.
- R4: When the true product exceeds the product width, `error_o` is 1 and `product_o` is 0. The overflow can come from a carry out of the accumulation or from a carry out of the doubling.
- R5: Let the clock edge that accepts `start_i` be edge 0. In the no-error case, `done_o` is high right after edge 1+n. Here n is the bit position of the factor's highest set bit plus one, and n is 0 for a zero factor. The both-wide error also ends after edge 1. No operation runs more than FAC_W iterations.
- R6: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after the accepting edge until the cycle in which `done_o` rises, and it is never high together with `done_o`.
- R7: `product_o` and `error_o` keep their values from one `done_o` until the next operation completes.
- R8: `start_i` has no effect while `busy_o` is high. The result reported is the one for the operands that were accepted.
- R9: The accumulator is cleared when each operation starts, so no result depends on an earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| op_a_i | input | OP_W | First operand |
| op_b_i | input | OP_W | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | OP_W | Result, held until the next completion |
| error_o | output | 1 | Operand-width or overflow error, held with the product |

## Verification
The bench builds the block with its default OP_W of 16, so the factor is 8 bits wide. At this width the full range of factors is reachable, from zero to 0xFF. That covers the eight-iteration worst case with factor 0x80, products exactly at 0xFFFF, overflow from a doubling carry, and overflow from an accumulation carry, as well as the swap path and the both-wide path. Start pulses are also applied during a long eight-iteration run, to show that they change nothing.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

  localparam int unsigned HDM_OP_W_DEF = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } hdm_state_e;

endpackage

// File: rtl/hdm_select.sv
module hdm_select #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned FAC_W = OP_W / 2
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [FAC_W-1:0] fac_o,
  output logic [OP_W-1:0]  mult_o,
  output logic             wide_o,
  output logic             fac_zero_o
);

  function automatic logic upper_clear(input logic [OP_W-1:0] v);
    return (v[OP_W-1:FAC_W] == '0);
  endfunction

  logic b_fits;
  logic a_fits;

  assign b_fits = upper_clear(b_i);
  assign a_fits = upper_clear(a_i);

  always_comb begin
    fac_o  = '0;
    mult_o = '0;
    wide_o = 1'b0;
    if (b_fits) begin
      fac_o  = b_i[FAC_W-1:0];
      mult_o = a_i;
    end else if (a_fits) begin
      fac_o  = a_i[FAC_W-1:0];
      mult_o = b_i;
    end else begin
      wide_o = 1'b1;
    end
  end

  assign fac_zero_o = (fac_o == '0);

endmodule

// File: rtl/hdm_step.sv
module hdm_step #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned FAC_W = OP_W / 2
) (
  input  logic [FAC_W-1:0] fac_i,
  input  logic [OP_W-1:0]  mult_i,
  input  logic [OP_W-1:0]  acc_i,
  output logic [FAC_W-1:0] fac_o,
  output logic [OP_W-1:0]  mult_o,
  output logic [OP_W-1:0]  acc_o,
  output logic             add_ovf_o,
  output logic             dbl_ovf_o,
  output logic             fin_o,
  output logic             err_o
);

  function automatic logic [OP_W:0] add_wide(input logic [OP_W-1:0] x,
                                             input logic [OP_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [OP_W:0] twice(input logic [OP_W-1:0] x);
    return {x, 1'b0};
  endfunction

  logic            out_bit;
  logic [OP_W-1:0] addend;
  logic [OP_W:0]   sum_w;
  logic [OP_W:0]   dbl_w;
  logic            last;

  assign out_bit = fac_i[0];
  assign fac_o   = fac_i >> 1;
  assign addend  = out_bit ? mult_i : '0;
  assign sum_w   = add_wide(acc_i, addend);
  assign dbl_w   = twice(mult_i);
  assign last    = (fac_o == '0);

  assign acc_o     = sum_w[OP_W-1:0];
  assign mult_o    = dbl_w[OP_W-1:0];
  assign add_ovf_o = sum_w[OP_W];
  assign dbl_ovf_o = dbl_w[OP_W] && !last && !add_ovf_o;
  assign fin_o     = add_ovf_o || last || dbl_ovf_o;
  assign err_o     = add_ovf_o || dbl_ovf_o;

endmodule

// File: rtl/hdm_ctrl.sv
module hdm_ctrl
  import hdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wide_i,
  input  logic fac_zero_i,
  input  logic step_fin_i,
  output logic busy_o,
  output logic cap_evt_o,
  output logic load_evt_o,
  output logic iter_evt_o,
  output logic fin_setup_o,
  output logic fin_run_o
);

  hdm_state_e state_q;
  hdm_state_e state_d;

  assign busy_o      = (state_q != ST_IDLE);
  assign cap_evt_o   = (state_q == ST_IDLE) && start_i;
  assign fin_setup_o = (state_q == ST_SETUP) && (wide_i || fac_zero_i);
  assign load_evt_o  = (state_q == ST_SETUP) && !wide_i && !fac_zero_i;
  assign iter_evt_o  = (state_q == ST_RUN);
  assign fin_run_o   = iter_evt_o && step_fin_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SETUP;
      ST_SETUP: state_d = fin_setup_o ? ST_IDLE : ST_RUN;
      ST_RUN:   if (step_fin_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R5: the setup state lasts exactly one cycle
  p_setup_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |=> (state_q != ST_SETUP));

  // R6: only one completion source at a time
  p_one_fin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_setup_o && fin_run_o));

endmodule

// File: rtl/hdm_mul_top.sv
module hdm_mul_top #(
  parameter int unsigned OP_W = hdm_pkg::HDM_OP_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [OP_W-1:0] product_o,
  output logic            error_o
);

  localparam int unsigned FAC_W  = OP_W / 2;
  localparam int unsigned ITER_W = $clog2(FAC_W + 1);

  logic [OP_W-1:0]  a_q, b_q;
  logic [FAC_W-1:0] fac_q;
  logic [OP_W-1:0]  mult_q, acc_q;

  logic [FAC_W-1:0] sel_fac;
  logic [OP_W-1:0]  sel_mult;
  logic             sel_wide, sel_zero;

  logic [FAC_W-1:0] nxt_fac;
  logic [OP_W-1:0]  nxt_mult, nxt_acc;
  logic             add_ovf, dbl_ovf, step_fin, step_err;

  logic cap_evt, load_evt, iter_evt, fin_setup, fin_run, fin_evt;

  logic            done_q, err_q;
  logic [OP_W-1:0] prod_q;

  hdm_select #(.OP_W(OP_W), .FAC_W(FAC_W)) u_select (
    .a_i        (a_q),
    .b_i        (b_q),
    .fac_o      (sel_fac),
    .mult_o     (sel_mult),
    .wide_o     (sel_wide),
    .fac_zero_o (sel_zero)
  );

  hdm_step #(.OP_W(OP_W), .FAC_W(FAC_W)) u_step (
    .fac_i     (fac_q),
    .mult_i    (mult_q),
    .acc_i     (acc_q),
    .fac_o     (nxt_fac),
    .mult_o    (nxt_mult),
    .acc_o     (nxt_acc),
    .add_ovf_o (add_ovf),
    .dbl_ovf_o (dbl_ovf),
    .fin_o     (step_fin),
    .err_o     (step_err)
  );

  hdm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wide_i      (sel_wide),
    .fac_zero_i  (sel_zero),
    .step_fin_i  (step_fin),
    .busy_o      (busy_o),
    .cap_evt_o   (cap_evt),
    .load_evt_o  (load_evt),
    .iter_evt_o  (iter_evt),
    .fin_setup_o (fin_setup),
    .fin_run_o   (fin_run)
  );

  assign fin_evt = fin_setup || fin_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      fac_q  <= '0;
      mult_q <= '0;
      acc_q  <= '0;
    end else begin
      if (cap_evt) begin
        a_q <= op_a_i;
        b_q <= op_b_i;
      end
      if (load_evt) begin
        fac_q  <= sel_fac;
        mult_q <= sel_mult;
        acc_q  <= '0;
      end else if (iter_evt && !step_fin) begin
        fac_q  <= nxt_fac;
        mult_q <= nxt_mult;
        acc_q  <= nxt_acc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      prod_q <= '0;
      err_q  <= 1'b0;
    end else begin
      done_q <= fin_evt;
      if (fin_setup) begin
        prod_q <= '0;
        err_q  <= sel_wide;
      end else if (fin_run) begin
        prod_q <= step_err ? '0 : nxt_acc;
        err_q  <= step_err;
      end
    end
  end

  assign done_o    = done_q;
  assign product_o = prod_q;
  assign error_o   = err_q;

  // Iteration counter kept only for the bound check
  logic [ITER_W-1:0] chk_iter;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_iter <= '0;
    else if (load_evt) chk_iter <= '0;
    else if (iter_evt) chk_iter <= chk_iter + 1'b1;
  end

  // R5: no more iterations than factor bits
  p_iter_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iter_evt |-> (chk_iter < ITER_W'(FAC_W)));

  // R6: completion pulse lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: busy and done never overlap
  p_busy_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R4: any error reports a zero product
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (product_o == '0));

  // R2: both-wide operands end in error
  p_wide_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_setup && sel_wide) |=> (error_o && done_o));

  // R7: results move only on completion
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt |=> ($stable(product_o) && $stable(error_o)));

  // R8: captured operands untouched while busy
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(a_q) && $stable(b_q)));

  // R9: accumulator starts from zero
  p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (acc_q == '0));

endmodule

// File: tb/hdm_mul_top_bench.sv
module hdm_mul_top_bench;

  localparam int unsigned OP_W  = 16;
  localparam int unsigned FAC_W = OP_W / 2;

  typedef struct {
    logic [OP_W-1:0] prod;
    logic            err;
    int              lat;
    int              t0;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [OP_W-1:0] op_a_i = '0;
  logic [OP_W-1:0] op_b_i = '0;
  logic            busy_o, done_o, error_o;
  logic [OP_W-1:0] product_o;

  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  bit   prev_done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdm_mul_top #(.OP_W(OP_W)) u_hdm_mul_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o),
    .error_o   (error_o)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    exp_t e;
    longint full;
    logic [FAC_W-1:0] f;
    int top;
    e.t0 = 0;
    if (a[OP_W-1:FAC_W] != 0 && b[OP_W-1:FAC_W] != 0) begin
      e.prod = '0; e.err = 1'b1; e.lat = 2;
      return e;
    end
    f = (b[OP_W-1:FAC_W] == 0) ? b[FAC_W-1:0] : a[FAC_W-1:0];
    full = longint'(a) * longint'(b);
    top = 0;
    for (int i = 0; i < FAC_W; i++) if (f[i]) top = i + 1;
    if (full > longint'({OP_W{1'b1}})) begin
      e.prod = '0; e.err = 1'b1; e.lat = -1;
    end else begin
      e.prod = full[OP_W-1:0]; e.err = 1'b0; e.lat = 2 + top;
    end
    return e;
  endfunction

  task automatic run_op(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input bit poke);
    exp_t e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    e = model(a, b);
    e.t0 = cyc;
    sb.push_back(e);
    op_a_i = a; op_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      op_a_i = ~a; op_b_i = 16'h0003; start_i = 1'b1;  // R8: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 hold product", product_o == e.prod, product_o, e.prod);
    check("R7 hold error", error_o == e.err, error_o, e.err);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check("R6 done one cycle", !done_o, done_o, 0);
      if (done_o) begin
        exp_t e;
        check("R6 busy low at done", !busy_o, busy_o, 0);
        if (sb.size() == 0) begin
          check("R8 unexpected done", 1'b0, 1, 0);
        end else begin
          e = sb.pop_front();
          check("R1/R3 product", product_o == e.prod, product_o, e.prod);
          check("R2/R4 error", error_o == e.err, error_o, e.err);
          if (e.lat >= 0) check("R5 latency", (cyc - e.t0) == e.lat, cyc - e.t0, e.lat);
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    check("reset busy", busy_o == 1'b0, busy_o, 0);
    check("reset done", done_o == 1'b0, done_o, 0);
    check("reset product", product_o == '0, product_o, 0);
    check("reset error", error_o == 1'b0, error_o, 0);
    rst_n = 1'b1;
    run_op(16'd44, 16'd51, 1'b0);        // R3
    run_op(16'd51, 16'd44, 1'b0);        // R1 factor from b
    run_op(16'h0FFF, 16'h0010, 1'b0);    // R1
    run_op(16'h0010, 16'h0FFF, 1'b0);    // R1 swap path
    run_op(16'h1234, 16'h5678, 1'b0);    // R2 both wide
    run_op(16'h1234, 16'h0000, 1'b0);    // R3 zero factor
    run_op(16'h0000, 16'h0000, 1'b0);    // R3
    run_op(16'hFFFF, 16'h0001, 1'b0);    // R3 max fits
    run_op(16'h0101, 16'h00FF, 1'b0);    // R3 0xFFFF, 8 iterations
    run_op(16'hFFFF, 16'h0002, 1'b0);    // R4 doubling carry
    run_op(16'h7FFF, 16'h0003, 1'b0);    // R4 accumulation carry
    run_op(16'h1234, 16'h00FF, 1'b0);    // R4
    run_op(16'h01FF, 16'h0080, 1'b1);    // R5 worst case, R8 poke
    run_op(16'd3, 16'd5, 1'b0);          // R9 after error run
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 3 == 0) run_op(lf, {8'h00, lf[7:0] ^ 8'h5A}, 1'b0);
      else if (i % 3 == 1) run_op({8'h00, lf[15:8]}, lf, 1'b0);
      else run_op({4'h0, lf[11:0]}, {12'h000, lf[3:0]}, 1'b0);
    end
    repeat (4) @(negedge clk);
    check("R8 scoreboard empty", sb.size() == 0, sb.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule